// File: doc/BRIEF.md
# Translation table walk address generator

This block walks a multi-level, long-descriptor translation table in hardware. A walk begins with a virtual address, the low bits of a table base register, an input-address size, a granule stride and a starting level. A one-bit regime flag selects between a 48-bit and a 40-bit descriptor output-address width. The stride is log2 of the granule minus 3: 9 for 4 KB, 11 for 16 KB and 13 for 64 KB.

At each level the walker builds the 8-byte-aligned address of the next descriptor. It reads that descriptor over a valid/ready request channel and a response strobe, with only one read in flight at any time. It then classifies the entry. A table entry moves the walk down one level and ORs the entry's upper attribute bits into a running attribute set. A block or page entry ends the walk with an output-address base, and any malformed entry ends it with a fault. Every result is reported by a single-cycle done pulse. Once the accumulated non-secure attribute is set, all later fetches in that walk are non-secure.

Top module: `tablewalk_engine`

## Requirements
- R1: While reset is low and after it is released, `busy_o`, `rd_req_o` and `done_o` are 0 until a walk is started. A reset during a walk returns the block to idle.
- R2: First fetch: let N = in_size − stride×(4−start_level). The base is `tbase_i` with its low N bits cleared. The index is (va >> stride×(4−level)) restricted to its low N bits. The fetch address is base OR index, with bits [2:0] forced to 0.
- R3: Later fetches: the base is the previous table descriptor's bits [47:0] when `wide_i`=1, or bits [39:0] when `wide_i`=0, with the low stride+3 bits cleared. The index mask is the low stride+3 bits, and bits [2:0] of the address are 0.
- R4: Descriptor bits [1:0] are decoded as follows. 2'b11 below level 3 is a table entry, and 2'b11 at level 3 is a page. 2'b01 at level 1 or 2 is a block. Any other value ends the walk with `fault_o`=1, and `lvl_o` gives the level of the failing descriptor.
- R5: Each table descriptor followed ORs its bits [63:59] into `attr_o`, so that attr bit k comes from descriptor bit 59+k. The set starts at 0 for each walk.
- R6: `rd_ns_o` equals accumulated attribute bit 4 (descriptor bit 63). Within a walk, once it is 1 it stays 1.
- R7: `rd_req_o`, `rd_addr_o` and `rd_ns_o` stay steady until `rd_ack_i`. After the handshake, no new request is made until `rd_rsp_i` has been seen.
- R8: `done_o` is a one-cycle pulse. For a leaf entry, `out_base_o` is the descriptor, masked to the regime width, with the low stride×(4−level)+3 bits cleared, and `fault_o`=0. On a fault, `out_base_o` is 0.
- R9: `start_i` while busy has no effect: the walk in progress keeps its own addresses and result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a walk (accepted only when idle) |
| va_i | input | 64 | Virtual address to translate |
| tbase_i | input | 48 | Table base register, low bits |
| in_size_i | input | 7 | Input address size in bits |
| stride_i | input | 4 | Granule stride (9, 11 or 13) |
| start_lvl_i | input | 2 | Starting level |
| wide_i | input | 1 | 1: 48-bit descriptor addresses, 0: 40-bit |
| busy_o | output | 1 | Walk in progress |
| rd_req_o | output | 1 | Descriptor read request valid |
| rd_addr_o | output | 48 | Descriptor address |
| rd_ns_o | output | 1 | Non-secure fetch |
| rd_ack_i | input | 1 | Request accepted |
| rd_rsp_i | input | 1 | Read data valid |
| rd_data_i | input | 64 | Descriptor returned |
| done_o | output | 1 | Walk finished pulse |
| fault_o | output | 1 | Translation fault |
| lvl_o | output | 2 | Level at which the walk ended |
| out_base_o | output | 48 | Output address base of the leaf |
| attr_o | output | 5 | Accumulated table attributes |

## Verification
Several properties are checked on every cycle by the assertions. A request holds steady while not acknowledged, and no second request follows a handshake before its response arrives. The non-secure flag never falls within a walk, and the done pulse lasts one cycle. A successful walk never ends at level 0, and a start during a walk leaves the latched address alone. The mask arithmetic is shown only by the bench's scenarios, which compare every fetch address, the final base, the level and the attributes with an independent model across three granules, both regimes and several start levels. The same applies to the decode of each leaf and fault type.

// File: rtl/tw_pkg.sv
package tw_pkg;

  typedef enum logic [1:0] {TW_IDLE, TW_REQ, TW_WAIT} tw_state_e;
  typedef enum logic [1:0] {DK_TABLE, DK_LEAF, DK_FAULT} desc_kind_e;

  // Mask of the n lowest bits; n >= 64 yields all ones.
  function automatic logic [63:0] low_mask(input logic [6:0] n);
    if (n >= 7'd64) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // Bit position of the index field for a given level.
  function automatic logic [6:0] level_shift(input logic [3:0] stride, input logic [1:0] lvl);
    return 7'(stride) * 7'(3'd4 - {1'b0, lvl});
  endfunction

endpackage

// File: rtl/tw_addr_calc.sv
module tw_addr_calc #(
  parameter int PA_W = 48
) (
  input  logic [63:0]     va_i,
  input  logic [PA_W-1:0] base_i,
  input  logic [63:0]     idx_mask_i,
  input  logic [6:0]      shift_i,
  output logic [PA_W-1:0] addr_o
);
  logic [63:0] idx;
  assign idx    = (va_i >> shift_i) & idx_mask_i;
  assign addr_o = PA_W'(({{(64-PA_W){1'b0}}, base_i} | idx) & ~64'd7);
endmodule

// File: rtl/tw_desc_decode.sv
module tw_desc_decode
  import tw_pkg::*;
(
  input  logic [1:0]  tag_i,
  input  logic [1:0]  lvl_i,
  output desc_kind_e  kind_o
);
  always_comb begin
    kind_o = DK_FAULT;
    unique case (tag_i)
      2'b11:   kind_o = (lvl_i == 2'd3) ? DK_LEAF : DK_TABLE;
      2'b01:   kind_o = (lvl_i == 2'd1 || lvl_i == 2'd2) ? DK_LEAF : DK_FAULT;
      default: kind_o = DK_FAULT;
    endcase
  end
endmodule

// File: rtl/tablewalk_engine.sv
module tablewalk_engine
  import tw_pkg::*;
#(
  parameter int PA_W     = 48,
  parameter int NARROW_W = 40,
  parameter int ATTR_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [63:0]       va_i,
  input  logic [PA_W-1:0]   tbase_i,
  input  logic [6:0]        in_size_i,
  input  logic [3:0]        stride_i,
  input  logic [1:0]        start_lvl_i,
  input  logic              wide_i,
  output logic              busy_o,
  output logic              rd_req_o,
  output logic [PA_W-1:0]   rd_addr_o,
  output logic              rd_ns_o,
  input  logic              rd_ack_i,
  input  logic              rd_rsp_i,
  input  logic [63:0]       rd_data_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        lvl_o,
  output logic [PA_W-1:0]   out_base_o,
  output logic [ATTR_W-1:0] attr_o
);
  localparam int ATTR_LSB = 64 - ATTR_W;
  localparam int NS_BIT   = ATTR_W - 1;

  tw_state_e        state_q;
  logic [63:0]      va_q;
  logic [3:0]       stride_q;
  logic             wide_q;
  logic [1:0]       lvl_q;
  logic [PA_W-1:0]  base_q;
  logic [63:0]      idx_mask_q;
  logic [ATTR_W-1:0] attr_q;
  logic             done_q, fault_q;
  logic [PA_W-1:0]  out_base_q;

  // Named internal events
  logic        start_ok, rd_fire, rsp_take, step_table;
  logic [6:0]  cur_shift, first_n;
  logic [63:0] reg_mask, first_mask;
  desc_kind_e  kind;

  assign start_ok   = start_i && (state_q == TW_IDLE);
  assign rd_fire    = rd_req_o && rd_ack_i;
  assign rsp_take   = (state_q == TW_WAIT) && rd_rsp_i;
  assign step_table = rsp_take && (kind == DK_TABLE);
  assign cur_shift  = level_shift(stride_q, lvl_q);
  assign first_n    = in_size_i - level_shift(stride_i, start_lvl_i);
  assign first_mask = low_mask(first_n);
  assign reg_mask   = wide_q ? low_mask(7'(PA_W)) : low_mask(7'(NARROW_W));

  tw_addr_calc #(.PA_W(PA_W)) u_addr (
    .va_i       (va_q),
    .base_i     (base_q),
    .idx_mask_i (idx_mask_q),
    .shift_i    (cur_shift),
    .addr_o     (rd_addr_o)
  );

  tw_desc_decode u_dec (
    .tag_i  (rd_data_i[1:0]),
    .lvl_i  (lvl_q),
    .kind_o (kind)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= TW_IDLE;
      va_q       <= '0;
      stride_q   <= '0;
      wide_q     <= 1'b0;
      lvl_q      <= '0;
      base_q     <= '0;
      idx_mask_q <= '0;
      attr_q     <= '0;
      done_q     <= 1'b0;
      fault_q    <= 1'b0;
      out_base_q <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        TW_IDLE: if (start_ok) begin
          va_q       <= va_i;
          stride_q   <= stride_i;
          wide_q     <= wide_i;
          lvl_q      <= start_lvl_i;
          idx_mask_q <= first_mask;
          base_q     <= tbase_i & ~first_mask[PA_W-1:0];
          attr_q     <= '0;
          state_q    <= TW_REQ;
        end
        TW_REQ: if (rd_fire) state_q <= TW_WAIT;
        TW_WAIT: if (rsp_take) begin
          if (kind == DK_TABLE) begin
            attr_q     <= attr_q | rd_data_i[63:ATTR_LSB];
            base_q     <= PA_W'(rd_data_i & reg_mask & ~low_mask(7'(stride_q) + 7'd3));
            idx_mask_q <= low_mask(7'(stride_q) + 7'd3);
            lvl_q      <= lvl_q + 2'd1;
            state_q    <= TW_REQ;
          end else begin
            done_q     <= 1'b1;
            fault_q    <= (kind == DK_FAULT);
            out_base_q <= (kind == DK_FAULT) ? '0
                        : PA_W'(rd_data_i & reg_mask & ~low_mask(cur_shift + 7'd3));
            state_q    <= TW_IDLE;
          end
        end
        default: state_q <= TW_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != TW_IDLE);
  assign rd_req_o   = (state_q == TW_REQ);
  assign rd_ns_o    = attr_q[NS_BIT];
  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign lvl_o      = lvl_q;
  assign out_base_o = out_base_q;
  assign attr_o     = attr_q;

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o) && $stable(rd_ns_o)); // R7
  AST_SINGLE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> !rd_req_o); // R7
  AST_NS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) && $past(rd_ns_o) |-> rd_ns_o); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_NO_L0_LEAF: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !fault_o |-> lvl_o != 2'd0); // R4
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && start_i |=> $stable(va_q)); // R9

endmodule

// File: tb/tablewalk_engine_tb_top.sv
module tablewalk_engine_tb_top;

  typedef struct packed {
    logic [63:0] va;
    logic [47:0] tbase;
    logic [6:0]  isz;
    logic [3:0]  stride;
    logic [1:0]  lvl;
    logic        wide;
    logic        hold;
    logic        poke;
    logic [63:0] d0, d1, d2, d3;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{64'h0000_1234_5678_9ABC, 48'h0000_4000_0000, 7'd48, 4'd9, 2'd0, 1'b1, 1'b1, 1'b1,
      64'h0000_0000_4010_0003, 64'h8000_0000_4020_0003, 64'h0000_0000_4030_0003, 64'h0000_00AB_CDE0_0003},
    '{64'h0000_0000_7FC0_1238, 48'h0000_8000_1FFF, 7'd39, 4'd9, 2'd1, 1'b1, 1'b0, 1'b0,
      64'h8000_0000_C000_0001, 64'h0, 64'h0, 64'h0},
    '{64'h0000_02AB_CDEF_0120, 48'h0000_5000_0000, 7'd42, 4'd13, 2'd2, 1'b1, 1'b1, 1'b0,
      64'h8800_0000_5001_0003, 64'h0000_1234_5678_0003, 64'h0, 64'h0},
    '{64'hFFFF_FFFF_C123_4560, 48'h0000_0000_0FE0, 7'd32, 4'd9, 2'd1, 1'b0, 1'b0, 1'b0,
      64'hFFFF_FF12_3456_7003, 64'h0000_0000_0020_0001, 64'h0, 64'h0},
    '{64'h0000_00FF_0000_0000, 48'h0000_1000_0000, 7'd48, 4'd9, 2'd0, 1'b1, 1'b0, 1'b0,
      64'h1, 64'h0, 64'h0, 64'h0},
    '{64'h0000_7FFF_FFFF_FFF8, 48'h0000_2000_0000, 7'd47, 4'd11, 2'd1, 1'b1, 1'b0, 1'b0,
      64'h0000_0001_2345_4003, 64'h0, 64'h0, 64'h0},
    '{64'h0000_0000_3FFF_F008, 48'h0000_0030_0000, 7'd30, 4'd9, 2'd2, 1'b1, 1'b1, 1'b0,
      64'h0000_0000_1000_0003, 64'h0000_0000_0000_5001, 64'h0, 64'h0},
    '{64'h0000_0040_0000_0000, 48'h0000_0700_0000, 7'd39, 4'd9, 2'd1, 1'b1, 1'b0, 1'b0,
      64'h0000_0000_0000_0002, 64'h0, 64'h0, 64'h0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] va_i = '0;
  logic [47:0] tbase_i = '0;
  logic [6:0]  in_size_i = '0;
  logic [3:0]  stride_i = '0;
  logic [1:0]  start_lvl_i = '0;
  logic        wide_i = 1'b0;
  logic        rd_ack_i = 1'b0, rd_rsp_i = 1'b0;
  logic [63:0] rd_data_i = '0;
  logic        busy_o, rd_req_o, rd_ns_o, done_o, fault_o;
  logic [47:0] rd_addr_o, out_base_o;
  logic [1:0]  lvl_o;
  logic [4:0]  attr_o;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  tablewalk_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .va_i(va_i), .tbase_i(tbase_i),
    .in_size_i(in_size_i), .stride_i(stride_i), .start_lvl_i(start_lvl_i), .wide_i(wide_i),
    .busy_o(busy_o), .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_ns_o(rd_ns_o),
    .rd_ack_i(rd_ack_i), .rd_rsp_i(rd_rsp_i), .rd_data_i(rd_data_i),
    .done_o(done_o), .fault_o(fault_o), .lvl_o(lvl_o), .out_base_o(out_base_o), .attr_o(attr_o)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Independent bit-loop model helpers
  function automatic logic [63:0] zap_low(input logic [63:0] x, input int n);
    for (int i = 0; i < 64; i++) if (i < n) x[i] = 1'b0;
    return x;
  endfunction

  function automatic logic [63:0] keep_low(input logic [63:0] x, input int n);
    for (int i = 0; i < 64; i++) if (i >= n) x[i] = 1'b0;
    return x;
  endfunction

  function automatic logic [63:0] pick(input vec_t v, input int k);
    case (k)
      0: return v.d0;
      1: return v.d1;
      2: return v.d2;
      default: return v.d3;
    endcase
  endfunction

  task automatic run_walk(input vec_t v);
    logic [63:0] mbase, d, ebase, held;
    int mn, mlvl, width, sh;
    logic [4:0] mattr;
    bit efault, fin;
    mlvl  = v.lvl;
    mn    = int'(v.isz) - int'(v.stride) * (4 - mlvl);
    mbase = zap_low({16'h0, v.tbase}, mn);
    width = v.wide ? 48 : 40;
    mattr = '0; efault = 1'b0; ebase = '0; fin = 1'b0;
    @(negedge clk);
    va_i = v.va; tbase_i = v.tbase; in_size_i = v.isz; stride_i = v.stride;
    start_lvl_i = v.lvl; wide_i = v.wide; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < 4 && !fin; k++) begin
      while (!rd_req_o && !done_o) @(negedge clk);
      sh = int'(v.stride) * (4 - mlvl);
      chk({16'h0, rd_addr_o} == zap_low(mbase | keep_low(v.va >> sh, mn), 3),
          (k == 0) ? "R2 first address" : "R3 next address",
          {16'h0, rd_addr_o}, zap_low(mbase | keep_low(v.va >> sh, mn), 3));
      chk(rd_ns_o == mattr[4], "R6 ns flag", {63'h0, rd_ns_o}, {63'h0, mattr[4]});
      if (v.hold) begin
        held = {16'h0, rd_addr_o};
        if (v.poke && k == 0) begin
          va_i = ~v.va; tbase_i = 48'hFFFF_FFFF_F000; start_lvl_i = 2'd3; start_i = 1'b1;
        end
        @(negedge clk);
        start_i = 1'b0;
        chk(rd_req_o && ({16'h0, rd_addr_o} == held), "R7 request held",
            {16'h0, rd_addr_o}, held);
        if (v.poke && k == 0)
          chk(busy_o && ({16'h0, rd_addr_o} == held), "R9 start ignored while busy",
              {16'h0, rd_addr_o}, held);
      end
      rd_ack_i = 1'b1;
      @(negedge clk);
      rd_ack_i = 1'b0;
      chk(!rd_req_o, "R7 single outstanding", {63'h0, rd_req_o}, 64'h0);
      @(negedge clk);
      d = pick(v, k);
      rd_rsp_i = 1'b1; rd_data_i = d;
      @(negedge clk);
      rd_rsp_i = 1'b0;
      if (d[1:0] == 2'b11 && mlvl < 3) begin
        mattr = mattr | d[63:59];
        mbase = zap_low(keep_low(d, width), int'(v.stride) + 3);
        mn    = int'(v.stride) + 3;
        mlvl++;
      end else begin
        fin = 1'b1;
        efault = !((d[1:0] == 2'b11 && mlvl == 3) ||
                   (d[1:0] == 2'b01 && (mlvl == 1 || mlvl == 2)));
        ebase = efault ? 64'h0 : zap_low(keep_low(d, width), sh + 3);
      end
    end
    chk(done_o == 1'b1, "R8 done pulse", {63'h0, done_o}, 64'h1);
    chk(fault_o == efault, "R4 fault", {63'h0, fault_o}, {63'h0, efault});
    chk(int'(lvl_o) == mlvl, "R4 level", {62'h0, lvl_o}, 64'(mlvl));
    chk({16'h0, out_base_o} == ebase, "R8 output base", {16'h0, out_base_o}, ebase);
    chk(attr_o == mattr, "R5 attributes", {59'h0, attr_o}, {59'h0, mattr});
    @(negedge clk);
    chk(!done_o && !busy_o, "R8 done one cycle", {62'h0, done_o, busy_o}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: walk did not complete, actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy_o && !rd_req_o && !done_o, "R1 in reset", {61'h0, busy_o, rd_req_o, done_o}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy_o && !rd_req_o && !done_o, "R1 after reset", {61'h0, busy_o, rd_req_o, done_o}, 64'h0);

    for (int i = 0; i < NV; i++) run_walk(VECS[i]);

    // Directed: reset during a walk returns to idle (R1)
    @(negedge clk);
    va_i = 64'h0000_0000_1234_5000; tbase_i = 48'h0000_0100_0000; in_size_i = 7'd39;
    stride_i = 4'd9; start_lvl_i = 2'd1; wide_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && rd_req_o, "R1 walk started before reset", {62'h0, busy_o, rd_req_o}, 64'h3);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !rd_req_o && !done_o, "R1 reset mid-walk", {61'h0, busy_o, rd_req_o, done_o}, 64'h0);

    // A fresh walk works after the mid-walk reset
    run_walk(VECS[1]);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule